// File: doc/BRIEF.md
# Console UART Register Block

This block is a register-level model of a classic 8250-class serial port, as seen by software. It sits on a byte-wide memory-mapped register bus with a 3-bit offset, separate read and write strobes, and 8-bit data. No serial bit timing is modelled. Received bytes come from a console byte stream through a valid/ready input and wait in a small holding buffer. Bytes that software writes to the data offset leave at once as a one-cycle pulse on a byte output.

One level-sensitive interrupt line tells software that a byte is waiting or that the transmitter is ready again. The transmit-ready notice is deliberately late: a write of a byte arms a countdown, and only when the countdown expires, with the transmit-ready interrupt still enabled, is the transmit pending flag raised. The interrupt identification offset returns a plain "something is pending" bit. A loopback probe of the modem control offset is answered with a fixed value, so that a driver probing for the port finds one. The divisor-latch window, the FIFO control write, the modem status and the scratch offset exist only so that drivers find the expected behaviour there.

Top module: `con_uart_regs`

## Requirements
- R1: After reset, `irq` is 0 and `rx_ready` is 1. Reads at offsets 1 (interrupt enable), 2 (identification), 3 (line control) and 4 (modem control) return 0, and offset 5 returns 0x60.
- R2: While line-control bit 7 is 0, a read at offset 0 returns the oldest buffered received byte and removes it; bytes leave in arrival order. When the buffer is empty the read returns 0.
- R3: While line-control bit 7 is 0, a write at offset 0 drives `tx_valid` high for exactly the one cycle after the write edge, with `tx_data` equal to the written byte.
- R4: While line-control bit 7 is 1, reads at offsets 0 and 1 return 0, and writes there change nothing: no byte is sent, no byte is removed and the enable value is kept.
- R5: Offset 1 reads back the last enable value written. Offset 3 reads back the last line-control value written. Offsets 6 and 7 always read 0. Writes at offsets 2, 5, 6 and 7 change nothing.
- R6: A read at offset 5 returns 0x60, with bit 0 set when at least one received byte is buffered.
- R7: A read at offset 2 returns 1 when the RX pending or the TX pending flag is set, and 0 otherwise.
- R8: A data write clears TX pending and drops `irq`. If enable bit 1 is set, it also loads a countdown of TX_DELAY cycles; a further data write reloads the full count.
- R9: When the countdown expires (TX_DELAY clock edges after the loading write), TX pending is set and `irq` rises, provided enable bit 1 is set after that cycle's writes. A data write in the expiry cycle reloads the countdown, and that expiry does not take effect.
- R10: An enable write sets `irq` to 1 when the new bit 1 is set, or when the new bit 0 is set and a byte is buffered. Otherwise it drops `irq` and cancels a running countdown. The write clears TX pending when the new bit 1 is 0, and clears RX pending unless the new bit 0 is set and a byte is buffered.
- R11: A byte accepted while enable bit 0 is set raises RX pending and `irq`. After a data read, `irq` is 1 if bytes remain, counting any byte accepted in the same cycle; otherwise RX pending and `irq` are cleared.
- R12: A write of exactly 0x1A at offset 4 makes offset 4 read 0x9A from then on. Any other write there is ignored.
- R13: The receive buffer holds RX_DEPTH bytes. `rx_ready` is 0 while the buffer is full, and a byte offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one access per cycle |
| reg_wr | input | 1 | Write strobe, never together with reg_rd |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle reg_rd is high |
| rx_data | input | 8 | Received console byte |
| rx_valid | input | 1 | rx_data is offered |
| rx_ready | output | 1 | Buffer can take a byte |
| tx_data | output | 8 | Transmitted byte |
| tx_valid | output | 1 | One-cycle pulse per transmitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can fall in one cycle. First, the countdown can expire on the same edge as a new data write; the bench waits exactly TX_DELAY-1 edges after a write before writing again, and expects `irq` to stay low and to rise only a full TX_DELAY edges after the second write. Second, a byte can arrive in the same cycle as a data read that empties the buffer; the bench offers the byte and reads in one cycle, and expects `irq` to stay high because a byte still remains. A behavioural model in the bench is compared with the outputs on every clock, so each of these edges is also judged cycle by cycle.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_IID   = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } ofs_e;

  localparam int          IEN_RX_BIT    = 0;
  localparam int          IEN_TX_BIT    = 1;
  localparam int          LCTL_LATCH_BIT = 7;
  localparam logic [7:0]  PROBE_WR      = 8'h1A;
  localparam logic [7:0]  PROBE_RD      = 8'h9A;

  // Line status: transmitter always idle (bits 6,5), byte waiting in bit 0.
  function automatic logic [7:0] lstat_value(input logic avail);
    return {1'b0, 1'b1, 1'b1, 4'b0000, avail};
  endfunction

  // Does a newly written enable value request the interrupt line?
  function automatic logic ien_posts(input logic [7:0] ien, input logic avail);
    return ien[IEN_TX_BIT] | (ien[IEN_RX_BIT] & avail);
  endfunction

endpackage

// File: rtl/con_uart_rxbuf.sv
module con_uart_rxbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/con_uart_txdelay.sv
module con_uart_txdelay #(
  parameter int DELAY = 300,
  localparam int TW   = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic fire,
  output logic busy
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= TW'(DELAY);
    else if (cancel)         cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == TW'(1)) && !start && !cancel;

  // R9
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |=> !busy);
  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> (cnt_q == TW'(DELAY)));

endmodule

// File: rtl/con_uart_regs.sv
module con_uart_regs
  import con_uart_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int TX_DELAY = 300,
  localparam int CW      = $clog2(RX_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       irq
);

  logic [7:0] ien_q, lctl_q, mctl_q, tx_data_q;
  logic       tx_valid_q, irq_q, rx_pend_q, tx_pend_q;
  logic       irq_n, rx_pend_n, tx_pend_n;

  // Named internal events
  logic latch_sel, rd_ev, data_wr_ev, data_rd_ev, ien_wr_ev, lctl_wr_ev, mctl_wr_ev;
  logic avail, rx_push, rx_pop, rx_full, rx_empty;
  logic tmr_start, tmr_cancel, tmr_fire, tmr_busy;
  logic tx_expire_ev, rx_arrive_ev, ien_posts_w;
  logic [7:0]    rx_head, ien_next, rd_mux;
  logic [CW-1:0] rx_count;
  logic [CW:0]   rx_left;

  assign latch_sel  = lctl_q[LCTL_LATCH_BIT];
  assign rd_ev      = reg_rd && !reg_wr;
  assign data_wr_ev = reg_wr && (reg_addr == OFS_DATA) && !latch_sel;
  assign data_rd_ev = rd_ev  && (reg_addr == OFS_DATA) && !latch_sel;
  assign ien_wr_ev  = reg_wr && (reg_addr == OFS_IEN)  && !latch_sel;
  assign lctl_wr_ev = reg_wr && (reg_addr == OFS_LCTL);
  assign mctl_wr_ev = reg_wr && (reg_addr == OFS_MCTL);

  assign avail    = !rx_empty;
  assign rx_ready = !rx_full;
  assign rx_push  = rx_valid && !rx_full;
  assign rx_pop   = data_rd_ev && avail;
  assign rx_left  = {1'b0, rx_count} - (CW+1)'(rx_pop) + (CW+1)'(rx_push);

  assign ien_next     = ien_wr_ev ? reg_wdata : ien_q;
  assign ien_posts_w  = ien_posts(reg_wdata, avail);
  assign tmr_start    = data_wr_ev && ien_q[IEN_TX_BIT];
  assign tmr_cancel   = ien_wr_ev && !ien_posts_w;
  assign tx_expire_ev = tmr_fire && ien_next[IEN_TX_BIT];
  assign rx_arrive_ev = rx_push && ien_next[IEN_RX_BIT];

  con_uart_rxbuf #(.DEPTH(RX_DEPTH), .W(8)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data), .pop(rx_pop),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  con_uart_txdelay #(.DELAY(TX_DELAY)) u_txdelay (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .cancel(tmr_cancel),
    .fire(tmr_fire), .busy(tmr_busy)
  );

  // Pending/interrupt update: register access first, then timer and arrival.
  always_comb begin
    irq_n     = irq_q;
    rx_pend_n = rx_pend_q;
    tx_pend_n = tx_pend_q;
    if (data_wr_ev) begin
      irq_n     = 1'b0;
      tx_pend_n = 1'b0;
    end
    if (ien_wr_ev) begin
      irq_n = ien_posts_w;
      if (!reg_wdata[IEN_TX_BIT]) tx_pend_n = 1'b0;
      if (!(reg_wdata[IEN_RX_BIT] && avail)) rx_pend_n = 1'b0;
    end
    if (data_rd_ev) begin
      if (rx_left != '0) irq_n = 1'b1;
      else begin
        irq_n     = 1'b0;
        rx_pend_n = 1'b0;
      end
    end
    if (tx_expire_ev) begin
      tx_pend_n = 1'b1;
      irq_n     = 1'b1;
    end
    if (rx_arrive_ev) begin
      rx_pend_n = 1'b1;
      irq_n     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q      <= '0;
      lctl_q     <= '0;
      mctl_q     <= '0;
      tx_data_q  <= '0;
      tx_valid_q <= 1'b0;
      irq_q      <= 1'b0;
      rx_pend_q  <= 1'b0;
      tx_pend_q  <= 1'b0;
    end else begin
      tx_valid_q <= data_wr_ev;
      if (data_wr_ev) tx_data_q <= reg_wdata;
      if (ien_wr_ev)  ien_q     <= reg_wdata;
      if (lctl_wr_ev) lctl_q    <= reg_wdata;
      if (mctl_wr_ev && (reg_wdata == PROBE_WR)) mctl_q <= PROBE_RD;
      irq_q     <= irq_n;
      rx_pend_q <= rx_pend_n;
      tx_pend_q <= tx_pend_n;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_DATA:  rd_mux = latch_sel ? 8'h00 : (avail ? rx_head : 8'h00);
      OFS_IEN:   rd_mux = latch_sel ? 8'h00 : ien_q;
      OFS_IID:   rd_mux = {7'b0, rx_pend_q | tx_pend_q};
      OFS_LCTL:  rd_mux = lctl_q;
      OFS_MCTL:  rd_mux = mctl_q;
      OFS_LSTAT: rd_mux = lstat_value(avail);
      OFS_MSTAT: rd_mux = 8'h00;
      OFS_SCR:   rd_mux = 8'h00;
      default:   rd_mux = 8'h00;
    endcase
  end

  assign reg_rdata = rd_ev ? rd_mux : 8'h00;
  assign tx_data   = tx_data_q;
  assign tx_valid  = tx_valid_q;
  assign irq       = irq_q;

  // R3
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> $past(data_wr_ev));
  // R8
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) data_wr_ev |=> !tx_pend_q);
  // R9
  tx_expire_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_expire_ev |=> (tx_pend_q && irq));
  // R11
  rx_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_arrive_ev |=> (rx_pend_q && irq));
  // R12
  probe_val_chk: assert property (@(posedge clk) disable iff (!rst_n) (mctl_q != 8'h00) |-> (mctl_q == PROBE_RD));
  // R10
  ien_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n) tmr_cancel |=> !tmr_busy);

endmodule

// File: tb/con_uart_regs_tb.sv
module con_uart_regs_tb;

  localparam int DEPTH = 4;
  localparam int DELAY = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] rx_data = '0, tx_data;
  logic       rx_valid = 1'b0, rx_ready, tx_valid, irq;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  con_uart_regs #(.RX_DEPTH(DEPTH), .TX_DELAY(DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] mq[$];
  int   mier, mlcr, mmcr, mtimer;
  bit   mrxp, mtxp, mirq, mtxv;
  int   mtxb;

  function automatic int m_rd(input int a);
    bit latch = mlcr[7];
    case (a)
      0: return latch ? 0 : (mq.size() > 0 ? int'(mq[0]) : 0);
      1: return latch ? 0 : mier;
      2: return (mrxp || mtxp) ? 1 : 0;
      3: return mlcr;
      4: return mmcr;
      5: return 'h60 | (mq.size() > 0 ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit avail, push, pop, fire, latch;
    int nt, nier, left;
    if (!rst_n) begin
      mq.delete(); mier = 0; mlcr = 0; mmcr = 0; mtimer = 0;
      mrxp = 0; mtxp = 0; mirq = 0; mtxv = 0; mtxb = 0;
      return;
    end
    avail = mq.size() > 0;
    push  = rx_valid && (mq.size() < DEPTH);
    latch = mlcr[7];
    fire  = (mtimer == 1);
    nt    = (mtimer > 0) ? mtimer - 1 : 0;
    nier  = mier;
    pop   = 0;
    mtxv  = 0;
    if (reg_wr) begin
      if (reg_addr == 0 && !latch) begin
        mtxv = 1; mtxb = reg_wdata; mirq = 0; mtxp = 0;
        if (mier[1]) begin nt = DELAY; fire = 0; end
      end else if (reg_addr == 1 && !latch) begin
        nier = reg_wdata;
        if (reg_wdata[1] || (reg_wdata[0] && avail)) mirq = 1;
        else begin mirq = 0; nt = 0; fire = 0; end
        if (!reg_wdata[1]) mtxp = 0;
        if (!(reg_wdata[0] && avail)) mrxp = 0;
      end else if (reg_addr == 3) mlcr = reg_wdata;
      else if (reg_addr == 4 && reg_wdata == 8'h1A) mmcr = 'h9A;
    end else if (reg_rd && reg_addr == 0 && !latch) begin
      pop  = avail;
      left = mq.size() - (pop ? 1 : 0) + (push ? 1 : 0);
      if (left > 0) mirq = 1;
      else begin mirq = 0; mrxp = 0; end
    end
    mier = nier;
    if (fire && mier[1]) begin mtxp = 1; mirq = 1; end
    if (push && mier[0]) begin mrxp = 1; mirq = 1; end
    if (pop)  void'(mq.pop_front());
    if (push) mq.push_back(rx_data);
    mtimer = nt;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    cyc++;
    model_step();
    #5;
    if (rst_n) begin
      check("R8 R9 R10 R11 irq", irq, mirq);
      check("R13 rx_ready", rx_ready, (mq.size() < DEPTH) ? 1 : 0);
      check("R3 tx_valid", tx_valid, mtxv);
      if (mtxv) check("R3 tx_data", tx_data, mtxb);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  // ---------------- stimulus tasks (start and end at a falling edge) ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = a[2:0]; reg_wdata = d[7:0]; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr = a[2:0]; reg_rd = 1'b1;
    #2;
    check(tag, reg_rdata, exp);
    check({tag, " model"}, reg_rdata, m_rd(a));
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rx(input int b);
    rx_data = b[7:0]; rx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rx_and_rd(input int b, input int exp, input string tag);
    rx_data = b[7:0]; rx_valid = 1'b1;
    rd(0, exp, tag);
    rx_valid = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 rx_ready", rx_ready, 1);
    rd(1, 0, "R1 ien");
    rd(2, 0, "R1 iid");
    rd(3, 0, "R1 lctl");
    rd(4, 0, "R1 mctl");
    rd(5, 'h60, "R6 lstat empty");
    rd(0, 0, "R2 empty data read");

    // R5 plain registers
    wr(3, 'h03);  rd(3, 'h03, "R5 lctl readback");
    wr(7, 'h55);  rd(7, 0, "R5 scratch");
    wr(2, 'hC7);  rd(2, 0, "R5 fcr ignored");
    rd(6, 0, "R5 mstat");

    // R3 transmit with enable clear, no countdown
    wr(0, 'h41);
    idle(DELAY + 10);
    rd(2, 0, "R9 no expiry when disabled");

    // R10 enable write with bit1, R8 restart, R9 expiry
    wr(1, 'h02);
    check("R10 irq on tx enable", irq, 1);
    rd(2, 0, "R7 iid not pending yet");
    rd(1, 'h02, "R5 ien readback");
    wr(0, 'h42);
    check("R8 irq dropped by write", irq, 0);
    idle(150);
    wr(0, 'h43);
    idle(DELAY - 1);
    check("R8 restarted count not expired", irq, 0);
    idle(1);
    check("R9 expiry irq", irq, 1);
    rd(2, 1, "R7 iid pending");

    // R10 clearing enable drops irq and TX pending
    wr(1, 'h00);
    check("R10 irq cleared", irq, 0);
    rd(2, 0, "R10 tx pending cleared");

    // R10 cancel of running countdown
    wr(1, 'h02);
    wr(0, 'h44);
    wr(1, 'h00);
    wr(1, 'h02);
    idle(DELAY + 10);
    rd(2, 0, "R10 cancelled countdown");

    // R9 collision: data write on the expiry edge
    wr(0, 'h31);
    idle(DELAY - 1);
    wr(0, 'h32);
    check("R9 collision irq", irq, 0);
    idle(DELAY - 1);
    check("R9 after collision not yet", irq, 0);
    idle(1);
    check("R9 after collision fired", irq, 1);

    // R11 receive interrupts
    wr(1, 'h01);
    check("R10 no rx data no irq", irq, 0);
    rx('h11);
    check("R11 arrival irq", irq, 1);
    rd(2, 1, "R11 rx pending");
    rd(5, 'h61, "R6 lstat data");
    rx('h22);
    rd(0, 'h11, "R2 first byte");
    check("R11 irq kept while bytes remain", irq, 1);
    rx_and_rd('h55, 'h22, "R11 read with arrival");
    check("R11 same-cycle arrival keeps irq", irq, 1);
    rd(0, 'h55, "R2 arrived byte");
    check("R11 irq cleared when empty", irq, 0);
    rd(2, 0, "R11 rx pending cleared");

    // R13 full buffer
    wr(1, 'h00);
    for (int i = 0; i < DEPTH; i++) rx('hA0 + i);
    check("R13 ready low when full", rx_ready, 0);
    rx('hEE);
    wr(1, 'h01);
    check("R10 irq when data buffered", irq, 1);
    rd(2, 0, "R10 rx pending not set by enable");
    wr(1, 'h00);
    for (int i = 0; i < DEPTH; i++) rd(0, 'hA0 + i, "R13 order kept");
    rd(0, 0, "R2 drained read");

    // R4 latch window
    wr(3, 'h80);
    wr(0, 'h77);
    wr(1, 'hFF);
    rx('h66);
    rd(0, 0, "R4 data masked");
    rd(1, 0, "R4 ien masked");
    wr(3, 'h03);
    rd(1, 0, "R4 ien unchanged");
    rd(0, 'h66, "R4 byte not removed");

    // R12 probe
    wr(4, 'h10);
    rd(4, 0, "R12 other write ignored");
    wr(4, 'h1A);
    rd(4, 'h9A, "R12 probe answer");

    idle(5);
    finish_run();
  end

endmodule